// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous 16-bit parallel flash bus. A client hands it one request at a time over a valid/ready handshake. The requests are: write a single word, erase the whole array, erase everything outside the boot region, lock the boot region, or fetch an identification word. The block turns each request into the fixed train of unlock writes that the flash expects. It times every strobe by counting system clock cycles, and it reports a one-cycle completion pulse with an error flag and a data word.

For the write, erase and lock requests, the script is followed by a polling phase. The sequencer reads the flash back to back and compares bit 6 of each read with the one before it. Two equal values in a row mean the device has finished its internal operation. If bit 6 is still changing when a per-operation cycle budget runs out, the request ends with an error.

For an identification request, the sequencer enters the identification mode and reads one word at the requested address. It then leaves the mode with a single write and returns the word it read.

Top module: `flash_cmd_seq`

## Requirements
- R1: While and right after reset: `req_ready`=1, `fl_we_n`=`fl_oe_n`=`fl_ce_n`=1, `fl_data_oe`=0, `done_valid`=0.
- R2: Operation code 0 (word write) issues exactly four bus writes, as address/data pairs: 5555/00AA, 2AAA/0055, 5555/00A0, and then the request's address and data. The upper byte of every command word is zero.
- R3: Codes 1, 2 and 3 (full erase, main erase, boot lock) each issue six writes: 5555/00AA, 2AAA/0055, 5555/0080, 5555/00AA, 2AAA/0055, and then 5555 with final data 0010, 0030 or 0040 in that order of codes.
- R4: `fl_we_n` stays low for at least WP_CYC = ceil(WE_LOW_NS/CLK_NS) cycles. Between two writes it stays high for at least max(ceil(WE_HIGH_NS/CLK_NS), ceil(ADDR_HOLD_NS/CLK_NS)) cycles. Address and write data hold steady while `fl_we_n` is low and on the cycle it rises, and `fl_data_oe` is 1 throughout.
- R5: `fl_we_n` and `fl_oe_n` are never low together, and `fl_ce_n` is low whenever either of them is low.
- R6: After the script, reads go to the request address for code 0 and to address 0 for codes 1 to 3. The request ends with `done_err`=0 on the first read whose bit 6 equals the previous read's bit 6, and `done_rdata` carries that read.
- R7: If bit 6 still differs when the cycle count since polling began reaches PROG_TIMEOUT_NS/CLK_NS (code 0) or ERASE_TIMEOUT_NS/CLK_NS (codes 1 to 3), the request ends with `done_err`=1.
- R8: `req_ready` is 1 only while the block is idle. A `req_valid` raised while the block is busy changes nothing on the bus.
- R9: Code 4 issues 5555/00AA, 2AAA/0055 and 5555/0090. It then makes one read at the request address, then one write of 00F0 to address 0000, and ends with `done_err`=0 and `done_rdata` equal to the word read.
- R10: `done_valid` is a one-cycle pulse, sent once per accepted request, and `req_ready` returns to 1 in the same cycle.
- R11: Codes 5 to 7 cause no bus cycle at all; `done_valid` and `done_err` are 1 in the cycle after acceptance, with `done_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Operation code (0 write, 1 full erase, 2 main erase, 3 boot lock, 4 identify) |
| req_addr | input | 16 | Target word address (write, identify) |
| req_data | input | 16 | Word to write |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion with timeout or bad code |
| done_rdata | output | 16 | Last word read from the flash |
| fl_addr | output | 16 | Flash address bus |
| fl_wdata | output | 16 | Data driven to the flash |
| fl_data_oe | output | 1 | Enable for the bidirectional data pad |
| fl_rdata | input | 16 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_we_n | output | 1 | Write strobe, active low |

## Verification
An unsupported code gives `done_valid` in the cycle after the accepting edge, and the bench checks that exact one-cycle latency. A write strobe rises WP_CYC cycles after it falls. The bench counts falling clock edges between strobe transitions, so every width it measures is a whole number of cycles. A polled request completes after max(B+1, 2) reads for a device that stays busy for B reads. A timed-out request cannot end before its cycle budget from acceptance. Every output is sampled on the falling clock edge, half a period away from the edge that updates it. The completion pulse is checked in the sample where it appears and again one sample later.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int AW = 16;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    OP_WORD_WR   = 3'd0,
    OP_FULL_ERA  = 3'd1,
    OP_MAIN_ERA  = 3'd2,
    OP_BOOT_LOCK = 3'd3,
    OP_IDENT     = 3'd4
  } fcs_op_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } fcs_wr_s;

  localparam logic [AW-1:0] KEY_ADDR_A = 16'h5555;
  localparam logic [AW-1:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]    KEY_BYTE_A = 8'hAA;
  localparam logic [7:0]    KEY_BYTE_B = 8'h55;
  localparam logic [7:0]    SETUP_ERA  = 8'h80;
  localparam logic [7:0]    LEAVE_ID   = 8'hF0;

  // clock cycles covering a time in ns, never less than one
  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [2:0] script_len(input fcs_op_e op);
    case (op)
      OP_WORD_WR:                            return 3'd4;
      OP_FULL_ERA, OP_MAIN_ERA, OP_BOOT_LOCK: return 3'd6;
      OP_IDENT:                              return 3'd3;
      default:                               return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] last_code(input fcs_op_e op);
    case (op)
      OP_WORD_WR:   return 8'hA0;
      OP_FULL_ERA:  return 8'h10;
      OP_MAIN_ERA:  return 8'h30;
      OP_BOOT_LOCK: return 8'h40;
      OP_IDENT:     return 8'h90;
      default:      return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcs_script.sv
module fcs_script
  import fcs_pkg::*;
(
  input  fcs_op_e       op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output fcs_wr_s       wr
);

  logic long_form;
  logic [DW-1:0] key_a, key_b, fin;

  assign long_form = (script_len(op) == 3'd6);
  assign key_a = {{(DW-8){1'b0}}, KEY_BYTE_A};
  assign key_b = {{(DW-8){1'b0}}, KEY_BYTE_B};
  assign fin   = {{(DW-8){1'b0}}, last_code(op)};

  always_comb begin
    wr = '{addr: KEY_ADDR_A, data: key_a};
    case (step)
      3'd0: wr = '{addr: KEY_ADDR_A, data: key_a};
      3'd1: wr = '{addr: KEY_ADDR_B, data: key_b};
      3'd2: wr = long_form ? '{addr: KEY_ADDR_A, data: {{(DW-8){1'b0}}, SETUP_ERA}}
                           : '{addr: KEY_ADDR_A, data: fin};
      3'd3: wr = long_form ? '{addr: KEY_ADDR_A, data: key_a}
                           : '{addr: tgt_addr, data: tgt_data};
      3'd4: wr = '{addr: KEY_ADDR_B, data: key_b};
      3'd5: wr = '{addr: KEY_ADDR_A, data: fin};
      default: wr = '{addr: KEY_ADDR_A, data: key_a};
    endcase
  end

endmodule

// File: rtl/fcs_bus_phy.sv
module fcs_bus_phy #(
  parameter int WP_CYC = 9,
  parameter int WH_CYC = 9,
  parameter int RD_CYC = 9,
  parameter int RH_CYC = 4,
  parameter int AW     = 16,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_oe,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  input  logic [DW-1:0] bus_rdata
);

  localparam int M1   = (WP_CYC > WH_CYC) ? WP_CYC : WH_CYC;
  localparam int M2   = (RD_CYC > RH_CYC) ? RD_CYC : RH_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_WLOW, PH_WHOLD, PH_RLOW, PH_RGAP} ph_e;

  ph_e           ph_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_oe    <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          bus_addr <= addr;
          ce_n     <= 1'b0;
          if (wr) begin
            bus_wdata <= wdata;
            bus_oe    <= 1'b1;
            we_n      <= 1'b0;
            cnt_q     <= CW'(WP_CYC - 1);
            ph_q      <= PH_WLOW;
          end else begin
            oe_n  <= 1'b0;
            cnt_q <= CW'(RD_CYC - 1);
            ph_q  <= PH_RLOW;
          end
        end
        PH_WLOW: if (last) begin
          we_n  <= 1'b1;
          cnt_q <= CW'(WH_CYC - 1);
          ph_q  <= PH_WHOLD;
        end else cnt_q <= cnt_q - 1'b1;
        PH_WHOLD: if (last) begin
          ce_n   <= 1'b1;
          bus_oe <= 1'b0;
          done   <= 1'b1;
          ph_q   <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RLOW: if (last) begin
          rdata <= bus_rdata;
          oe_n  <= 1'b1;
          ce_n  <= 1'b1;
          cnt_q <= CW'(RH_CYC - 1);
          ph_q  <= PH_RGAP;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RGAP: if (last) begin
          done <= 1'b1;
          ph_q <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fcs_poll.sv
module fcs_poll #(
  parameter int TW      = 28,
  parameter int TOG_BIT = 6,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample,
  output logic          settled,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic          prev_q;
  logic          have_q;

  assign expired = (cnt_q >= limit);
  assign settled = sample_valid && have_q && (sample[TOG_BIT] == prev_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      if (!expired) cnt_q <= cnt_q + 1'b1;
      if (sample_valid) begin
        prev_q <= sample[TOG_BIT];
        have_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int CLK_NS           = 5,
  parameter int WE_LOW_NS        = 45,
  parameter int WE_HIGH_NS       = 45,
  parameter int ADDR_HOLD_NS     = 45,
  parameter int READ_ACC_NS      = 45,
  parameter int OE_HIGH_NS       = 20,
  parameter int PROG_TIMEOUT_NS  = 50000,
  parameter int ERASE_TIMEOUT_NS = 1000000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  output logic        done_valid,
  output logic        done_err,
  output logic [15:0] done_rdata,
  output logic [15:0] fl_addr,
  output logic [15:0] fl_wdata,
  output logic        fl_data_oe,
  input  logic [15:0] fl_rdata,
  output logic        fl_ce_n,
  output logic        fl_oe_n,
  output logic        fl_we_n
);

  localparam int WP_CYC   = cyc_of(WE_LOW_NS, CLK_NS);
  localparam int WH_A     = cyc_of(WE_HIGH_NS, CLK_NS);
  localparam int WH_B     = cyc_of(ADDR_HOLD_NS, CLK_NS);
  localparam int WH_CYC   = (WH_A > WH_B) ? WH_A : WH_B;
  localparam int RD_CYC   = cyc_of(READ_ACC_NS, CLK_NS);
  localparam int RH_CYC   = cyc_of(OE_HIGH_NS, CLK_NS);
  localparam int PROG_TMO = cyc_of(PROG_TIMEOUT_NS, CLK_NS);
  localparam int ERA_TMO  = cyc_of(ERASE_TIMEOUT_NS, CLK_NS);
  localparam int TMO_MAX  = (PROG_TMO > ERA_TMO) ? PROG_TMO : ERA_TMO;
  localparam int TW       = $clog2(TMO_MAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_SCRIPT, S_POLL, S_IDREAD, S_IDEXIT} st_e;

  st_e           st_q;
  fcs_op_e       op_q;
  logic [AW-1:0] tgt_addr_q;
  logic [DW-1:0] tgt_data_q;
  logic [2:0]    step_q;
  logic          issue_q;
  logic          poll_clr_q;

  fcs_wr_s       scr_wr;
  logic          phy_wr, phy_done;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata, phy_rdata;
  logic          settled, expired;
  logic [TW-1:0] limit;
  fcs_op_e       req_op_e;

  assign req_op_e = fcs_op_e'(req_op);

  fcs_script u_script (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (tgt_addr_q),
    .tgt_data (tgt_data_q),
    .wr       (scr_wr)
  );

  always_comb begin
    phy_wr    = 1'b0;
    phy_addr  = '0;
    phy_wdata = '0;
    case (st_q)
      S_SCRIPT: begin
        phy_wr    = 1'b1;
        phy_addr  = scr_wr.addr;
        phy_wdata = scr_wr.data;
      end
      S_IDEXIT: begin
        phy_wr    = 1'b1;
        phy_wdata = {{(DW-8){1'b0}}, LEAVE_ID};
      end
      S_POLL:   phy_addr = (op_q == OP_WORD_WR) ? tgt_addr_q : '0;
      S_IDREAD: phy_addr = tgt_addr_q;
      default: ;
    endcase
  end

  fcs_bus_phy #(
    .WP_CYC (WP_CYC), .WH_CYC (WH_CYC), .RD_CYC (RD_CYC), .RH_CYC (RH_CYC),
    .AW (AW), .DW (DW)
  ) u_phy (
    .clk       (clk),
    .rst       (rst),
    .start     (issue_q),
    .wr        (phy_wr),
    .addr      (phy_addr),
    .wdata     (phy_wdata),
    .done      (phy_done),
    .rdata     (phy_rdata),
    .bus_addr  (fl_addr),
    .bus_wdata (fl_wdata),
    .bus_oe    (fl_data_oe),
    .ce_n      (fl_ce_n),
    .oe_n      (fl_oe_n),
    .we_n      (fl_we_n),
    .bus_rdata (fl_rdata)
  );

  assign limit = (op_q == OP_WORD_WR) ? TW'(PROG_TMO) : TW'(ERA_TMO);

  fcs_poll #(.TW (TW), .TOG_BIT (6), .DW (DW)) u_poll (
    .clk          (clk),
    .rst          (rst),
    .clr          (poll_clr_q),
    .limit        (limit),
    .sample_valid (phy_done && (st_q == S_POLL)),
    .sample       (phy_rdata),
    .settled      (settled),
    .expired      (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      op_q       <= OP_WORD_WR;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      step_q     <= '0;
      issue_q    <= 1'b0;
      poll_clr_q <= 1'b0;
      req_ready  <= 1'b1;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      done_rdata <= '0;
    end else begin
      issue_q    <= 1'b0;
      poll_clr_q <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid && req_ready) begin
          op_q       <= req_op_e;
          tgt_addr_q <= req_addr;
          tgt_data_q <= req_data;
          step_q     <= '0;
          if (script_len(req_op_e) == 3'd0) begin
            done_valid <= 1'b1;
            done_err   <= 1'b1;
            done_rdata <= '0;
          end else begin
            issue_q   <= 1'b1;
            req_ready <= 1'b0;
            st_q      <= S_SCRIPT;
          end
        end
        S_SCRIPT: if (phy_done) begin
          issue_q <= 1'b1;
          if (step_q == script_len(op_q) - 3'd1) begin
            if (op_q == OP_IDENT) st_q <= S_IDREAD;
            else begin
              st_q       <= S_POLL;
              poll_clr_q <= 1'b1;
            end
          end else step_q <= step_q + 3'd1;
        end
        S_POLL: if (phy_done) begin
          if (settled || expired) begin
            done_valid <= 1'b1;
            done_err   <= !settled;
            done_rdata <= phy_rdata;
            req_ready  <= 1'b1;
            st_q       <= S_IDLE;
          end else issue_q <= 1'b1;
        end
        S_IDREAD: if (phy_done) begin
          done_rdata <= phy_rdata;
          issue_q    <= 1'b1;
          st_q       <= S_IDEXIT;
        end
        S_IDEXIT: if (phy_done) begin
          done_valid <= 1'b1;
          req_ready  <= 1'b1;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int WP_CYC = 9,
  parameter int WH_CYC = 9
) (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        done_valid,
  input logic        done_err,
  input logic [15:0] fl_addr,
  input logic [15:0] fl_wdata,
  input logic        fl_data_oe,
  input logic        fl_ce_n,
  input logic        fl_oe_n,
  input logic        fl_we_n
);

  logic [15:0] low_run, high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= 16'hFFFF;
    end else begin
      low_run  <= fl_we_n ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
      high_run <= !fl_we_n ? '0 : ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1);
    end
  end

  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (low_run >= 16'(WP_CYC))); // R4
  AST_WE_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (high_run >= 16'(WH_CYC))); // R4
  AST_WR_BUS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R4
  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> ($stable(fl_addr) && fl_data_oe)); // R4
  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_data_oe); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n)); // R5
  AST_CE_COVERS: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R5
  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> req_ready); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done_valid); // R7

endmodule

bind flash_cmd_seq fcs_checker #(.WP_CYC (WP_CYC), .WH_CYC (WH_CYC)) u_fcs_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .done_valid (done_valid),
  .done_err   (done_err),
  .fl_addr    (fl_addr),
  .fl_wdata   (fl_wdata),
  .fl_data_oe (fl_data_oe),
  .fl_ce_n    (fl_ce_n),
  .fl_oe_n    (fl_oe_n),
  .fl_we_n    (fl_we_n)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

  localparam int CLK_NS  = 5;
  localparam int WP      = 9;
  localparam int WH      = 9;
  localparam int PROG_LIM = 400;
  localparam int ERA_LIM  = 800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic done_valid, done_err;
  logic [15:0] done_rdata, fl_addr, fl_wdata, fl_rdata;
  logic fl_data_oe, fl_ce_n, fl_oe_n, fl_we_n;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(
    .CLK_NS (CLK_NS), .PROG_TIMEOUT_NS (2000), .ERASE_TIMEOUT_NS (4000)
  ) i_flash_cmd_seq (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
    .req_op (req_op), .req_addr (req_addr), .req_data (req_data),
    .done_valid (done_valid), .done_err (done_err), .done_rdata (done_rdata),
    .fl_addr (fl_addr), .fl_wdata (fl_wdata), .fl_data_oe (fl_data_oe),
    .fl_rdata (fl_rdata), .fl_ce_n (fl_ce_n), .fl_oe_n (fl_oe_n), .fl_we_n (fl_we_n)
  );

  int nchk = 0, nfail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model: logs writes, toggles bit 6 on each read while busy
  logic [31:0] wlog [0:15];
  int wcnt = 0, rcnt = 0, busy = 0;
  logic tog = 1'b0, id_mode = 1'b0;
  logic [15:0] last_raddr = '0;
  int low_run = 0, high_run = 0, min_low = 1000, min_high = 1000, oe_bad = 0, overlap = 0;
  logic seen_wr = 1'b0, prev_we = 1'b1, prev_oe = 1'b1;

  function automatic logic [15:0] id_word(input logic [15:0] a);
    case (a)
      16'h0000: return 16'hC0DE;
      16'h0001: return 16'h0B17;
      16'h0002: return 16'h00FE;
      default:  return 16'h0000;
    endcase
  endfunction

  assign fl_rdata = id_mode ? id_word(fl_addr) : {9'b0, tog, 6'b0};

  always @(negedge clk) begin
    if (!fl_we_n && !fl_oe_n) overlap++;
    if (!fl_we_n) begin
      if (prev_we) begin
        if (seen_wr && high_run < min_high) min_high = high_run;
        low_run = 0;
      end
      low_run++;
    end else begin
      if (!prev_we) begin
        if (low_run < min_low) min_low = low_run;
        if (!fl_data_oe) oe_bad++;
        if (wcnt < 16) wlog[wcnt] = {fl_addr, fl_wdata};
        wcnt++;
        seen_wr = 1'b1;
        if (fl_wdata[7:0] == 8'h90) id_mode = 1'b1;
        if (fl_wdata[7:0] == 8'hF0) id_mode = 1'b0;
        high_run = 0;
      end
      high_run++;
    end
    if (!fl_oe_n && prev_oe) begin
      rcnt++;
      last_raddr = fl_addr;
      if (busy > 0) begin
        busy--;
        tog = ~tog;
      end
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  function automatic int exp_nwr(input int op);
    case (op)
      0, 4:    return 4;
      1, 2, 3: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_wr(input int op, input int i, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] fin;
    fin = (op == 1) ? 16'h0010 : (op == 2) ? 16'h0030 : 16'h0040;
    case (i)
      0: return {16'h5555, 16'h00AA};
      1: return {16'h2AAA, 16'h0055};
      2: return (op == 0) ? {16'h5555, 16'h00A0} : (op == 4) ? {16'h5555, 16'h0090} : {16'h5555, 16'h0080};
      3: return (op == 0) ? {a, d} : (op == 4) ? {16'h0000, 16'h00F0} : {16'h5555, 16'h00AA};
      4: return {16'h2AAA, 16'h0055};
      default: return {16'h5555, fin};
    endcase
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R2/R6";
      1, 2, 3: return "R3/R6";
      4: return "R9";
      default: return "R11";
    endcase
  endfunction

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic [19:0] busy;
    logic        exp_err;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h1234, 16'hBEEF, 20'd3,     1'b0, 16'h0040},
    '{3'd0, 16'h0000, 16'h0000, 20'd0,     1'b0, 16'h0000},
    '{3'd1, 16'h0000, 16'h0000, 20'd5,     1'b0, 16'h0040},
    '{3'd2, 16'h0000, 16'h0000, 20'd2,     1'b0, 16'h0000},
    '{3'd3, 16'h0000, 16'h0000, 20'd1,     1'b0, 16'h0040},
    '{3'd4, 16'h0000, 16'h0000, 20'd0,     1'b0, 16'hC0DE},
    '{3'd4, 16'h0002, 16'h0000, 20'd0,     1'b0, 16'h00FE},
    '{3'd0, 16'h00F0, 16'h1111, 20'd60000, 1'b1, 16'h0000},
    '{3'd1, 16'h0000, 16'h0000, 20'd60000, 1'b1, 16'h0000},
    '{3'd6, 16'h0000, 16'h0000, 20'd0,     1'b1, 16'h0000}
  };

  task automatic run_vec(input vec_t v);
    int cyc;
    int op;
    op = int'(v.op);
    @(negedge clk);
    wcnt = 0; rcnt = 0; busy = int'(v.busy); tog = 1'b0; seen_wr = 1'b0;
    check(req_ready === 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    if (op < 5) begin
      // R8: offer a different request while busy; it must not reach the bus
      req_op = 3'd2; req_addr = 16'h7777; req_data = 16'h9999;
      check(req_ready === 1'b0, "R8 ready low while busy", 32'(req_ready), 32'd0);
    end else req_valid = 1'b0;
    while (done_valid !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check(done_valid === 1'b1, {tag_of(op), " done seen"}, 32'(done_valid), 32'd1);
    check(done_err === v.exp_err, {tag_of(op), " R7 error flag"}, 32'(done_err), 32'(v.exp_err));
    check(req_ready === 1'b1, "R10 ready with done", 32'(req_ready), 32'd1);
    if (!v.exp_err)
      check(done_rdata === v.exp_rd, {tag_of(op), " result word"}, 32'(done_rdata), 32'(v.exp_rd));
    check(wcnt == exp_nwr(op), {tag_of(op), " R8 write count"}, 32'(wcnt), 32'(exp_nwr(op)));
    for (int i = 0; i < exp_nwr(op) && i < wcnt; i++)
      check(wlog[i] === exp_wr(op, i, v.addr, v.data), {tag_of(op), " script word"},
            wlog[i], exp_wr(op, i, v.addr, v.data));
    if (op < 4) begin
      check(last_raddr === ((op == 0) ? v.addr : 16'h0000), "R6 poll address",
            32'(last_raddr), 32'((op == 0) ? v.addr : 16'h0000));
      if (!v.exp_err) begin
        int er;
        er = (int'(v.busy) + 1 > 2) ? int'(v.busy) + 1 : 2;
        check(rcnt == er, "R6 poll read count", 32'(rcnt), 32'(er));
      end else begin
        int lim;
        lim = (op == 0) ? PROG_LIM : ERA_LIM;
        check(cyc >= lim, "R7 timeout not early", 32'(cyc), 32'(lim));
      end
    end else if (op == 4) begin
      check(rcnt == 1 && last_raddr === v.addr, "R9 single id read", 32'(rcnt), 32'd1);
    end else begin
      check(cyc == 1, "R11 one-cycle reject latency", 32'(cyc), 32'd1);
      check(rcnt == 0 && done_rdata === 16'h0, "R11 no read, zero data", 32'(rcnt), 32'd0);
    end
    @(negedge clk);
    check(done_valid === 1'b0, "R10 done is one pulse", 32'(done_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && done_valid === 1'b0, "R1 ready/done in reset", {req_ready, done_valid}, 2'b10);
    check({fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe} === 4'b1110, "R1 bus idle in reset",
          {fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    check({req_ready, fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe} === 5'b11110, "R1 after reset",
          {req_ready, fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe}, 5'b11110);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // reset in the middle of an erase script
    @(negedge clk);
    busy = 60000;
    req_valid = 1'b1; req_op = 3'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({req_ready, fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe, done_valid} === 6'b111100,
          "R1 mid-operation reset", {req_ready, fl_we_n, fl_oe_n, fl_ce_n, fl_data_oe, done_valid}, 6'b111100);
    rst = 1'b0;
    id_mode = 1'b0;
    run_vec(VECS[0]);

    check(min_low >= WP, "R4 write strobe low width", 32'(min_low), 32'(WP));
    check(min_high >= WH, "R4 strobe high between writes", 32'(min_high), 32'(WH));
    check(oe_bad == 0, "R4 data driven at strobe rise", 32'(oe_bad), 32'd0);
    check(overlap == 0, "R5 strobes never overlap", 32'(overlap), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule